// File: doc/BRIEF.md
# Bus Error Counter and Confinement Unit

This block holds the two fault counters of a node on a shared multi-master serial bus and decides how far that node is trusted. One counter is charged for faults while the node transmits, the other for faults while it receives. From the two counts the block derives a confinement state. In the active state the node signals faults with a dominant error flag. In the passive state it signals them with a recessive flag. In the bus-off state it stays off the bus until a long recessive stretch lets it recover.

The protocol engine feeds the block with one-cycle event pulses. These cover detected faults, a dominant level right after the node's own flag, bit errors inside an active or overload flag, and frame completions. A bit strobe carries the sampled bus level, one pulse per bit time. From that strobe the block itself counts dominant runs after flags, the recovery groups while bus-off, and the suspension window that a passive transmitter must leave after its own frame. Every output is a register that takes its new value on the clock edge at which the event is presented.

Top module: `bus_fault_confine`

## Requirements
- R1: After reset both counters read 0, the state is active (code 2'b00), `flag_rec_o` is 0 and `suspend_o` is 0.
- R2: The state code is 2'b10 (bus-off) when the transmit count exceeds 255. Otherwise it is 2'b01 (passive) when either count exceeds 127, and 2'b00 (active) in all other cases.
- R3: `flag_rec_o` is 0 in the active state and 1 in the passive and bus-off states.
- R4: A receiver fault pulse `rx_err_i` adds 1 to the receive count.
- R5: `dom_after_flag_i` adds 8 to the receive count. `tx_err_i` adds 8 to the transmit count.
- R6: `flag_bit_err_i` adds 8 to the transmit count when `role_tx_i` is 1. Otherwise it adds 8 to the receive count, and it never adds the extra 1 of R4.
- R7: `run_arm_i` restarts the dominant-run count, with the kind given by `run_passive_i`. For an active or overload flag (`run_passive_i`=0) the 14th dominant bit after arming adds 8. For a passive flag the 8th dominant bit adds 8. After that, every further 8 dominant bits add 8 again. The 8 goes to the transmit count if `role_tx_i`=1 and to the receive count otherwise. A recessive bit ends the run.
- R8: `tx_ok_i` subtracts 1 from a nonzero transmit count. A count of 0 stays at 0.
- R9: `rx_ok_i` sets the receive count to 127 when it is above 127. It leaves a count of 0 at 0 and otherwise subtracts 1.
- R10: Events in the same cycle all apply. The decrement of R8 or R9 is applied first, then all increments are added.
- R11: The receive count saturates at 511 and does not wrap. While bus-off, both counts hold and all fault and success events are ignored.
- R12: While bus-off, every 11 consecutive recessive bits form one group, and a dominant bit restarts the group in progress. Completing the 128th group clears both counts to 0 and returns the state to active.
- R13: `tx_done_i` in the passive state raises `suspend_o`. It falls after 8 further recessive bits, or at once on a dominant bit. In the active state `tx_done_i` leaves `suspend_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_err_i | input | 1 | Fault detected while receiving |
| tx_err_i | input | 1 | Fault detected while transmitting, at flag start |
| dom_after_flag_i | input | 1 | Dominant bit seen first after own error flag |
| flag_bit_err_i | input | 1 | Bit error while sending an active or overload flag |
| role_tx_i | input | 1 | 1 when the node is the transmitter of the frame |
| run_arm_i | input | 1 | Start of a flag; restarts the dominant-run count |
| run_passive_i | input | 1 | Kind of flag armed: 1 passive, 0 active or overload |
| bit_stb_i | input | 1 | One pulse per sampled bus bit |
| bit_rec_i | input | 1 | Level of the strobed bit, 1 recessive |
| tx_ok_i | input | 1 | Own transmission completed without fault |
| rx_ok_i | input | 1 | Reception completed without fault |
| tx_done_i | input | 1 | End of own frame and intermission |
| tec_o | output | 9 | Transmit fault count |
| rec_o | output | 9 | Receive fault count |
| state_o | output | 2 | Confinement state code |
| flag_rec_o | output | 1 | Error flag polarity, 1 recessive |
| suspend_o | output | 1 | Transmission held back for suspension |

## Verification
Each event pulse or bit strobe is presented for one cycle. Its effect on the counts, the state code, the flag polarity and the suspension output appears after exactly one clock edge, because the run, recovery and suspension decisions are combined into the same registers in that cycle. The bench drives inputs on the falling edge and reads every output on the next falling edge, so each check covers exactly one event. The bench steps the counts arithmetically through every value of each threshold sweep, the whole dominant run, and all 128 recovery groups.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
  typedef enum logic [1:0] {
    CONF_ACTIVE  = 2'b00,
    CONF_PASSIVE = 2'b01,
    CONF_BUSOFF  = 2'b10
  } conf_state_e;
endpackage

// File: rtl/bfc_run_watch.sv
// Counts dominant bits after a flag starts and pulses fire_o at each weighted threshold.
module bfc_run_watch #(
  parameter int ACT_FIRST = 14,
  parameter int PAS_FIRST = 8,
  parameter int STEP      = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  input  logic arm_i,
  input  logic arm_passive_i,
  input  logic bit_stb_i,
  input  logic bit_rec_i,
  output logic fire_o
);
  localparam int LIM_A  = (ACT_FIRST > PAS_FIRST) ? ACT_FIRST : PAS_FIRST;
  localparam int LIM_M  = (LIM_A > STEP) ? LIM_A : STEP;
  localparam int RW     = $clog2(LIM_M + 1);

  logic          armed_q, past_q, passive_q;
  logic [RW-1:0] cnt_q;
  logic [RW-1:0] lim;
  logic          dom, hit;

  always_comb begin
    dom = bit_stb_i && !bit_rec_i;
    if (past_q)         lim = RW'(STEP);
    else if (passive_q) lim = RW'(PAS_FIRST);
    else                lim = RW'(ACT_FIRST);
    hit    = armed_q && dom && !arm_i && (cnt_q + RW'(1) == lim);
    fire_o = hit && !hold_i;
  end

  always_ff @(posedge clk) begin
    if (rst || hold_i) begin
      armed_q   <= 1'b0;
      past_q    <= 1'b0;
      passive_q <= 1'b0;
      cnt_q     <= '0;
    end else if (arm_i) begin
      armed_q   <= 1'b1;
      past_q    <= 1'b0;
      passive_q <= arm_passive_i;
      cnt_q     <= '0;
    end else if (armed_q && bit_stb_i) begin
      if (bit_rec_i) begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else if (hit) begin
        past_q  <= 1'b1;
        cnt_q   <= '0;
      end else begin
        cnt_q   <= cnt_q + RW'(1);
      end
    end
  end

  // R7: thresholds are at least STEP bits apart, so two fires never touch
  p_fire_gap_r7: assert property (@(posedge clk) disable iff (rst)
    fire_o |=> !fire_o);
  // R7: a recessive bit ends the run, so the next cycle cannot fire
  p_rec_ends_run_r7: assert property (@(posedge clk) disable iff (rst)
    (bit_stb_i && bit_rec_i && !arm_i) |=> !fire_o);
endmodule

// File: rtl/bfc_recovery.sv
// Counts groups of consecutive recessive bits while bus-off.
module bfc_recovery #(
  parameter int GROUP_BITS = 11,
  parameter int GROUPS     = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic busoff_i,
  input  logic bit_stb_i,
  input  logic bit_rec_i,
  output logic done_o
);
  localparam int BW = $clog2(GROUP_BITS + 1);
  localparam int SW = $clog2(GROUPS + 1);

  logic [BW-1:0] bits_q;
  logic [SW-1:0] seq_q;
  logic          grp_end;

  always_comb begin
    grp_end = busoff_i && bit_stb_i && bit_rec_i && (bits_q == BW'(GROUP_BITS - 1));
    done_o  = grp_end && (seq_q == SW'(GROUPS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst || !busoff_i) begin
      bits_q <= '0;
      seq_q  <= '0;
    end else if (bit_stb_i) begin
      if (!bit_rec_i) begin
        bits_q <= '0;
      end else if (grp_end) begin
        bits_q <= '0;
        seq_q  <= done_o ? '0 : seq_q + SW'(1);
      end else begin
        bits_q <= bits_q + BW'(1);
      end
    end
  end

  // R12: a dominant bit while bus-off discards the partial group
  p_dom_restarts_r12: assert property (@(posedge clk) disable iff (rst)
    (busoff_i && bit_stb_i && !bit_rec_i) |=> (bits_q == '0));
endmodule

// File: rtl/bfc_suspend.sv
// Holds back transmission for a fixed number of recessive bits after a passive node's frame.
module bfc_suspend #(
  parameter int SUSP_BITS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic busoff_i,
  input  logic passive_i,
  input  logic tx_done_i,
  input  logic bit_stb_i,
  input  logic bit_rec_i,
  output logic susp_o
);
  localparam int CW = $clog2(SUSP_BITS + 1);

  logic          susp_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || busoff_i) begin
      susp_q <= 1'b0;
      cnt_q  <= '0;
    end else if (tx_done_i && passive_i) begin
      susp_q <= 1'b1;
      cnt_q  <= '0;
    end else if (susp_q && bit_stb_i) begin
      if (!bit_rec_i || cnt_q == CW'(SUSP_BITS - 1)) begin
        susp_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + CW'(1);
      end
    end
  end

  assign susp_o = susp_q;

  // R13: suspension only ever starts from a passive node finishing a frame
  p_susp_source_r13: assert property (@(posedge clk) disable iff (rst)
    $rose(susp_q) |-> $past(passive_i && tx_done_i));
  // R13: a dominant bit ends the wait at once
  p_susp_dom_end_r13: assert property (@(posedge clk) disable iff (rst)
    (susp_q && bit_stb_i && !bit_rec_i && !tx_done_i) |=> !susp_q);
endmodule

// File: rtl/bfc_counters.sv
// Transmit and receive fault counters with the confinement state register.
module bfc_counters
  import bfc_pkg::*;
#(
  parameter int CNT_W       = 9,
  parameter int PASSIVE_LIM = 127,
  parameter int BUSOFF_LIM  = 255,
  parameter int HEAVY_STEP  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_err_i,
  input  logic             tx_err_i,
  input  logic             dom_after_flag_i,
  input  logic             flag_bit_err_i,
  input  logic             role_tx_i,
  input  logic             run_fire_i,
  input  logic             tx_ok_i,
  input  logic             rx_ok_i,
  input  logic             recov_done_i,
  output logic [CNT_W-1:0] tec_o,
  output logic [CNT_W-1:0] rec_o,
  output conf_state_e      state_o,
  output logic             flag_rec_o
);
  localparam int          EXT     = CNT_W + 2;
  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] tec_q, rec_q, tec_nx, rec_nx;
  logic [EXT-1:0]   tec_inc, rec_inc, tec_base, rec_base, tec_sum, rec_sum;
  conf_state_e      state_q, state_nx;
  logic             flag_q;

  always_comb begin
    tec_inc = '0;
    rec_inc = '0;
    if (tx_err_i)                        tec_inc = tec_inc + EXT'(HEAVY_STEP);
    if (flag_bit_err_i &&  role_tx_i)    tec_inc = tec_inc + EXT'(HEAVY_STEP);
    if (run_fire_i     &&  role_tx_i)    tec_inc = tec_inc + EXT'(HEAVY_STEP);
    if (rx_err_i)                        rec_inc = rec_inc + EXT'(1);
    if (dom_after_flag_i)                rec_inc = rec_inc + EXT'(HEAVY_STEP);
    if (flag_bit_err_i && !role_tx_i)    rec_inc = rec_inc + EXT'(HEAVY_STEP);
    if (run_fire_i     && !role_tx_i)    rec_inc = rec_inc + EXT'(HEAVY_STEP);

    if (tx_ok_i && tec_q != '0) tec_base = EXT'(tec_q) - EXT'(1);
    else                        tec_base = EXT'(tec_q);

    if (!rx_ok_i)                           rec_base = EXT'(rec_q);
    else if (rec_q > CNT_W'(PASSIVE_LIM))   rec_base = EXT'(PASSIVE_LIM);
    else if (rec_q == '0)                   rec_base = '0;
    else                                    rec_base = EXT'(rec_q) - EXT'(1);

    tec_sum = tec_base + tec_inc;
    rec_sum = rec_base + rec_inc;
    tec_nx  = (tec_sum > EXT'(CNT_MAX)) ? CNT_W'(CNT_MAX) : tec_sum[CNT_W-1:0];
    rec_nx  = (rec_sum > EXT'(CNT_MAX)) ? CNT_W'(CNT_MAX) : rec_sum[CNT_W-1:0];

    if (state_q == CONF_BUSOFF) begin
      tec_nx = recov_done_i ? '0 : tec_q;
      rec_nx = recov_done_i ? '0 : rec_q;
    end

    if (tec_nx > CNT_W'(BUSOFF_LIM))
      state_nx = CONF_BUSOFF;
    else if (tec_nx > CNT_W'(PASSIVE_LIM) || rec_nx > CNT_W'(PASSIVE_LIM))
      state_nx = CONF_PASSIVE;
    else
      state_nx = CONF_ACTIVE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tec_q   <= '0;
      rec_q   <= '0;
      state_q <= CONF_ACTIVE;
      flag_q  <= 1'b0;
    end else begin
      tec_q   <= tec_nx;
      rec_q   <= rec_nx;
      state_q <= state_nx;
      flag_q  <= (state_nx != CONF_ACTIVE);
    end
  end

  assign tec_o      = tec_q;
  assign rec_o      = rec_q;
  assign state_o    = state_q;
  assign flag_rec_o = flag_q;

  // R2: the active code is never held with a count over the passive limit
  p_active_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == CONF_ACTIVE) |-> (tec_q <= CNT_W'(PASSIVE_LIM) && rec_q <= CNT_W'(PASSIVE_LIM)));
  // R3: flag polarity tracks the state register
  p_flag_polarity_r3: assert property (@(posedge clk) disable iff (rst)
    flag_q == (state_q != CONF_ACTIVE));
  // R9: a clean successful reception above the limit lands on the limit
  p_rx_ok_clamp_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q != CONF_BUSOFF && rx_ok_i && rec_q > CNT_W'(PASSIVE_LIM) && !rx_err_i &&
     !dom_after_flag_i && !(flag_bit_err_i && !role_tx_i) && !(run_fire_i && !role_tx_i))
    |=> (rec_q == CNT_W'(PASSIVE_LIM)));
  // R11: the receive count never wraps from its maximum
  p_rec_saturate_r11: assert property (@(posedge clk) disable iff (rst)
    (state_q != CONF_BUSOFF && rec_q == CNT_W'(CNT_MAX) && !rx_ok_i) |=> (rec_q == CNT_W'(CNT_MAX)));
  // R11: counts are frozen in bus-off until recovery completes
  p_busoff_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (state_q == CONF_BUSOFF && !recov_done_i) |=> ($stable(tec_q) && $stable(rec_q)));
  // R12: recovery clears both counts and returns to active
  p_recover_clear_r12: assert property (@(posedge clk) disable iff (rst)
    (state_q == CONF_BUSOFF && recov_done_i) |=> (tec_q == '0 && rec_q == '0 && state_q == CONF_ACTIVE));
endmodule

// File: rtl/bus_fault_confine.sv
module bus_fault_confine
  import bfc_pkg::*;
#(
  parameter int CNT_W        = 9,
  parameter int PASSIVE_LIM  = 127,
  parameter int BUSOFF_LIM   = 255,
  parameter int HEAVY_STEP   = 8,
  parameter int RUN_ACT      = 14,
  parameter int RUN_PAS      = 8,
  parameter int RUN_STEP     = 8,
  parameter int RECOV_BITS   = 11,
  parameter int RECOV_GROUPS = 128,
  parameter int SUSP_BITS    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_err_i,
  input  logic             tx_err_i,
  input  logic             dom_after_flag_i,
  input  logic             flag_bit_err_i,
  input  logic             role_tx_i,
  input  logic             run_arm_i,
  input  logic             run_passive_i,
  input  logic             bit_stb_i,
  input  logic             bit_rec_i,
  input  logic             tx_ok_i,
  input  logic             rx_ok_i,
  input  logic             tx_done_i,
  output logic [CNT_W-1:0] tec_o,
  output logic [CNT_W-1:0] rec_o,
  output logic [1:0]       state_o,
  output logic             flag_rec_o,
  output logic             suspend_o
);
  conf_state_e state;
  logic        busoff, passive, run_fire, recov_done;

  assign busoff  = (state == CONF_BUSOFF);
  assign passive = (state == CONF_PASSIVE);

  bfc_run_watch #(
    .ACT_FIRST (RUN_ACT),
    .PAS_FIRST (RUN_PAS),
    .STEP      (RUN_STEP)
  ) u_run (
    .clk           (clk),
    .rst           (rst),
    .hold_i        (busoff),
    .arm_i         (run_arm_i),
    .arm_passive_i (run_passive_i),
    .bit_stb_i     (bit_stb_i),
    .bit_rec_i     (bit_rec_i),
    .fire_o        (run_fire)
  );

  bfc_recovery #(
    .GROUP_BITS (RECOV_BITS),
    .GROUPS     (RECOV_GROUPS)
  ) u_recov (
    .clk       (clk),
    .rst       (rst),
    .busoff_i  (busoff),
    .bit_stb_i (bit_stb_i),
    .bit_rec_i (bit_rec_i),
    .done_o    (recov_done)
  );

  bfc_counters #(
    .CNT_W       (CNT_W),
    .PASSIVE_LIM (PASSIVE_LIM),
    .BUSOFF_LIM  (BUSOFF_LIM),
    .HEAVY_STEP  (HEAVY_STEP)
  ) u_cnt (
    .clk              (clk),
    .rst              (rst),
    .rx_err_i         (rx_err_i),
    .tx_err_i         (tx_err_i),
    .dom_after_flag_i (dom_after_flag_i),
    .flag_bit_err_i   (flag_bit_err_i),
    .role_tx_i        (role_tx_i),
    .run_fire_i       (run_fire),
    .tx_ok_i          (tx_ok_i),
    .rx_ok_i          (rx_ok_i),
    .recov_done_i     (recov_done),
    .tec_o            (tec_o),
    .rec_o            (rec_o),
    .state_o          (state),
    .flag_rec_o       (flag_rec_o)
  );

  bfc_suspend #(
    .SUSP_BITS (SUSP_BITS)
  ) u_susp (
    .clk       (clk),
    .rst       (rst),
    .busoff_i  (busoff),
    .passive_i (passive),
    .tx_done_i (tx_done_i),
    .bit_stb_i (bit_stb_i),
    .bit_rec_i (bit_rec_i),
    .susp_o    (suspend_o)
  );

  assign state_o = state;
endmodule

// File: tb/bus_fault_confine_tb_top.sv
module bus_fault_confine_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_err_i = 0, tx_err_i = 0, dom_after_flag_i = 0, flag_bit_err_i = 0;
  logic role_tx_i = 0, run_arm_i = 0, run_passive_i = 0, bit_stb_i = 0, bit_rec_i = 0;
  logic tx_ok_i = 0, rx_ok_i = 0, tx_done_i = 0;
  logic [8:0] tec_o, rec_o;
  logic [1:0] state_o;
  logic       flag_rec_o, suspend_o;

  int n_chk = 0;
  int n_fail = 0;
  int e_tec = 0;
  int e_rec = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_fault_confine dut_i (
    .clk(clk), .rst(rst), .rx_err_i(rx_err_i), .tx_err_i(tx_err_i),
    .dom_after_flag_i(dom_after_flag_i), .flag_bit_err_i(flag_bit_err_i),
    .role_tx_i(role_tx_i), .run_arm_i(run_arm_i), .run_passive_i(run_passive_i),
    .bit_stb_i(bit_stb_i), .bit_rec_i(bit_rec_i), .tx_ok_i(tx_ok_i), .rx_ok_i(rx_ok_i),
    .tx_done_i(tx_done_i), .tec_o(tec_o), .rec_o(rec_o), .state_o(state_o),
    .flag_rec_o(flag_rec_o), .suspend_o(suspend_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_state(input int t, input int r);
    if (t > 255) return 2;
    if (t > 127 || r > 127) return 1;
    return 0;
  endfunction

  task automatic chk_all(input string req);
    chk({req, " tec"}, int'(tec_o), e_tec);
    chk({req, " rec"}, int'(rec_o), e_rec);
    chk({req, " state R2"}, int'(state_o), exp_state(e_tec, e_rec));
    chk({req, " flag R3"}, int'(flag_rec_o), (exp_state(e_tec, e_rec) != 0) ? 1 : 0);
  endtask

  // inputs were set after a falling edge; one rising edge updates, next falling edge samples
  task automatic tick;
    @(negedge clk);
    rx_err_i = 0; tx_err_i = 0; dom_after_flag_i = 0; flag_bit_err_i = 0;
    run_arm_i = 0; run_passive_i = 0; bit_stb_i = 0; bit_rec_i = 0;
    tx_ok_i = 0; rx_ok_i = 0; tx_done_i = 0;
  endtask

  task automatic bit_in(input logic rec);
    bit_stb_i = 1; bit_rec_i = rec; tick();
  endtask

  task automatic do_reset;
    rst = 1; role_tx_i = 0;
    repeat (2) @(negedge clk);
    rst = 0; e_tec = 0; e_rec = 0;
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    do_reset();
    // R1 reset values
    chk("R1 tec", int'(tec_o), 0);
    chk("R1 rec", int'(rec_o), 0);
    chk("R1 state", int'(state_o), 0);
    chk("R1 flag", int'(flag_rec_o), 0);
    chk("R1 suspend", int'(suspend_o), 0);

    // R4 sweep receive faults across the passive limit (R2, R3)
    for (int i = 0; i < 200; i++) begin
      rx_err_i = 1; tick(); e_rec++;
      chk_all("R4 sweep");
    end
    // R9 clamp from above the limit, then step down to zero and hold
    rx_ok_i = 1; tick(); e_rec = 127;
    chk_all("R9 clamp");
    for (int i = 0; i < 130; i++) begin
      rx_ok_i = 1; tick(); e_rec = (e_rec == 0) ? 0 : e_rec - 1;
      chk_all("R9 step");
    end

    // R5 heavy increments
    dom_after_flag_i = 1; tick(); e_rec += 8; chk_all("R5 dom after flag");
    tx_err_i = 1; tick(); e_tec += 8; chk_all("R5 tx err");
    // R6 flag bit error by role
    role_tx_i = 1; flag_bit_err_i = 1; tick(); e_tec += 8; chk_all("R6 tx role");
    role_tx_i = 0; flag_bit_err_i = 1; tick(); e_rec += 8; chk_all("R6 rx role");
    // R10 combined events: rec 16 -> 15 then +1 +8
    rx_ok_i = 1; rx_err_i = 1; dom_after_flag_i = 1; tick(); e_rec = 24;
    chk_all("R10 combined rec");
    tx_ok_i = 1; tx_err_i = 1; tick(); e_tec = 23;
    chk_all("R10 combined tec");
    // R8 decrement down to zero and hold
    for (int i = 0; i < 26; i++) begin
      tx_ok_i = 1; tick(); e_tec = (e_tec == 0) ? 0 : e_tec - 1;
      chk_all("R8 tx ok");
    end

    // R7 active run with receiver role
    do_reset();
    role_tx_i = 0; run_arm_i = 1; run_passive_i = 0; tick(); chk_all("R7 arm");
    for (int k = 1; k <= 31; k++) begin
      bit_in(1'b0);
      if (k >= 14 && (k - 14) % 8 == 0) e_rec += 8;
      chk_all("R7 active run");
    end
    bit_in(1'b1); chk_all("R7 run end");
    for (int k = 1; k <= 16; k++) begin
      bit_in(1'b0); chk_all("R7 disarmed");
    end
    // R7 passive run with transmitter role
    role_tx_i = 1; run_arm_i = 1; run_passive_i = 1; tick();
    for (int k = 1; k <= 17; k++) begin
      bit_in(1'b0);
      if (k % 8 == 0) e_tec += 8;
      chk_all("R7 passive run");
    end
    role_tx_i = 0;

    // R11 receive saturation
    do_reset();
    for (int i = 0; i < 515; i++) begin
      rx_err_i = 1; tick(); e_rec = (e_rec >= 511) ? 511 : e_rec + 1;
      chk_all("R11 saturate");
    end
    rx_ok_i = 1; tick(); e_rec = 127; chk_all("R11 R9 after sat");

    // R13 suspension
    rx_err_i = 1; tick(); e_rec = 128; chk_all("R13 passive setup");
    tx_done_i = 1; tick(); chk("R13 raise", int'(suspend_o), 1);
    for (int k = 1; k <= 8; k++) begin
      bit_in(1'b1); chk("R13 count", int'(suspend_o), (k < 8) ? 1 : 0);
    end
    tx_done_i = 1; tick(); chk("R13 raise again", int'(suspend_o), 1);
    bit_in(1'b0); chk("R13 dominant ends", int'(suspend_o), 0);
    rx_ok_i = 1; tick(); e_rec = 127; chk_all("R13 active");
    tx_done_i = 1; tick(); chk("R13 active no suspend", int'(suspend_o), 0);

    // R2 bus-off entry via transmit faults
    do_reset();
    for (int i = 0; i < 32; i++) begin
      tx_err_i = 1; tick(); e_tec += 8; chk_all("R2 tec sweep");
    end
    // R11 events ignored while bus-off
    rx_err_i = 1; tick(); chk_all("R11 ignore rx err");
    tx_ok_i = 1; tick(); chk_all("R11 ignore tx ok");
    dom_after_flag_i = 1; tx_err_i = 1; tick(); chk_all("R11 ignore heavy");
    rx_ok_i = 1; tick(); chk_all("R11 ignore rx ok");

    // R12 recovery: 127 groups, a broken group, then the final group
    for (int g = 0; g < 127; g++) begin
      for (int b = 0; b < 11; b++) bit_in(1'b1);
    end
    chk_all("R12 after 127 groups");
    for (int b = 0; b < 10; b++) bit_in(1'b1);
    bit_in(1'b0);
    for (int b = 0; b < 10; b++) bit_in(1'b1);
    chk_all("R12 broken group");
    bit_in(1'b1); e_tec = 0; e_rec = 0;
    chk_all("R12 recovered");

    report();
  end
endmodule